// File: doc/BRIEF.md
# Masked Segmented Memory Access Unit

This block gives a host access to a 64-entry array of 64-bit words through a 32-bit data path. Each word also has a validity bit, which is held in its own flag. The host chooses the 32-bit half of any wide register or word with a segment select. The address-valid strobe decides how the control bus is read. With the strobe LOW the bus holds a direct array address. With the strobe HIGH it holds a command code, which selects one of three actions: an indirect access through an internal address register, an access to a mask register, or an access to the comparand register.

Writes to the array can be bit-masked. One of seven mask registers is selected, and only the bits that are LOW in that register take the new data. Mask code zero turns masking off. An indirect write takes its mask number from the command code. A direct write takes its mask number from a configuration register. The address register and the configuration register are loaded through a side port.

Every operation is qualified by `cyc` and takes effect on a rising clock edge. The read result is registered and appears on `rdata` and `vld_out_n` after that edge.

Top module: `seg_mem_access`

## Requirements
- R1: After reset, `rdata` is 0 and `vld_out_n` is 1. Every array word, mask register and the comparand are zero, and every entry is empty.
- R2: With `addr_strobe_n` LOW, `ctl[5:0]` addresses the array directly. A read returns the selected half on `rdata` in the cycle after the clock edge that took the operation.
- R3: An array write stores `!vld_in_n` as the entry's validity, where LOW means valid. An array read drives `vld_out_n` LOW for a valid entry and HIGH for an empty one. Every other operation leaves `vld_out_n` HIGH.
- R4: `hi_seg` = 0 selects bits 31..0 and `hi_seg` = 1 selects bits 63..32. Writing one half leaves the other half unchanged.
- R5: With `addr_strobe_n` HIGH and `ctl[5:0]` = 000000, the access goes to the entry held in the address register. That register is loaded when `ar_ld` is high.
- R6: An indirect write is masked by the mask register numbered by `ctl[8:6]`. Bits that are 1 in the mask keep their old value and bits that are 0 take `wdata`. Number 0 applies no mask.
- R7: `ctl[5:0]` = 001001 writes or reads mask register `ctl[8:6]`, in the half chosen by `hi_seg`. A write to register 0 has no effect, and a read of register 0 returns 0.
- R8: A direct write is masked by mask register `cfg[2:0]` when `cfg[3]` is 1, and is not masked when `cfg[3]` is 0. The configuration is loaded when `cfg_ld` is high.
- R9: `ctl[5:0]` = 000101 writes or reads the selected half of the comparand.
- R10: Any other command code changes no state, and it returns 0 on `rdata` and 1 on `vld_out_n`.
- R11: While `cyc` is low, no operation takes place and `rdata` and `vld_out_n` hold their values.
- R12: An operation with `wr_n` LOW drives `rdata` to 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc | input | 1 | Operation qualifier |
| addr_strobe_n | input | 1 | LOW: `ctl` holds an address; HIGH: `ctl` holds a command |
| wr_n | input | 1 | LOW writes, HIGH reads |
| hi_seg | input | 1 | Half select |
| ctl | input | 12 | Address or command code |
| wdata | input | 32 | Write data |
| vld_in_n | input | 1 | Validity to store, LOW means valid |
| ar_ld | input | 1 | Load address register |
| ar_val | input | 6 | Address register value |
| cfg_ld | input | 1 | Load configuration |
| cfg_val | input | 4 | [3] direct-write mask enable, [2:0] mask number |
| rdata | output | 32 | Read data |
| vld_out_n | output | 1 | Validity of the entry read, LOW means valid |

## Verification
A fault in the array, a mask register or the comparand stays hidden until the affected half is read back. It then appears on `rdata` one cycle after the read. For that reason the bench reads back every half it writes, and it also reads the neighbouring half. A masking fault appears as wrong bits inside a word whose other bits are correct. A validity fault appears on `vld_out_n` in the same cycle as the read data. A decode fault appears one cycle later, either as nonzero data after a write or unknown code, or as a register changing when it should have been left untouched.

// File: rtl/seg_mem_access.sv
module seg_mem_access #(
  parameter int ENTRIES = 64,
  parameter int HALF_W  = 32,
  parameter int CTL_W   = 12,
  parameter int MSEL_W  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cyc,
  input  logic                       addr_strobe_n,
  input  logic                       wr_n,
  input  logic                       hi_seg,
  input  logic [CTL_W-1:0]           ctl,
  input  logic [HALF_W-1:0]          wdata,
  input  logic                       vld_in_n,
  input  logic                       ar_ld,
  input  logic [$clog2(ENTRIES)-1:0] ar_val,
  input  logic                       cfg_ld,
  input  logic [MSEL_W:0]            cfg_val,
  output logic [HALF_W-1:0]          rdata,
  output logic                       vld_out_n
);
  localparam int AW     = $clog2(ENTRIES);
  localparam int WORD_W = 2 * HALF_W;
  localparam int NMASK  = 1 << MSEL_W;
  localparam logic [5:0] OP_IND  = 6'b000000;
  localparam logic [5:0] OP_MASK = 6'b001001;
  localparam logic [5:0] OP_CMP  = 6'b000101;

  logic [WORD_W-1:0] mem   [ENTRIES];
  logic [ENTRIES-1:0] valid;
  logic [WORD_W-1:0] mreg  [NMASK];
  logic [WORD_W-1:0] cmp_q;
  logic [AW-1:0]     ar_q;
  logic [MSEL_W:0]   cfg_q;

  wire              direct = !addr_strobe_n;
  wire [5:0]        op     = ctl[5:0];
  wire [MSEL_W-1:0] msel   = ctl[6 +: MSEL_W];
  wire is_mem  = direct || (op == OP_IND);
  wire is_mreg = !direct && (op == OP_MASK);
  wire is_cmp  = !direct && (op == OP_CMP);
  wire do_wr   = cyc && !wr_n;
  wire do_rd   = cyc && wr_n;

  wire [AW-1:0]     mem_addr = direct ? ctl[AW-1:0] : ar_q;
  wire [MSEL_W-1:0] wm_sel   = direct ? (cfg_q[MSEL_W] ? cfg_q[MSEL_W-1:0] : '0) : msel;
  wire [WORD_W-1:0] wm_word  = mreg[wm_sel];
  wire [WORD_W-1:0] old_word = mem[mem_addr];
  wire [HALF_W-1:0] wm_half  = hi_seg ? wm_word[WORD_W-1:HALF_W] : wm_word[HALF_W-1:0];
  wire [HALF_W-1:0] old_half = hi_seg ? old_word[WORD_W-1:HALF_W] : old_word[HALF_W-1:0];
  wire [HALF_W-1:0] new_half = (old_half & wm_half) | (wdata & ~wm_half);

  wire [WORD_W-1:0] mr_word  = mreg[msel];
  wire [HALF_W-1:0] mr_half  = hi_seg ? mr_word[WORD_W-1:HALF_W] : mr_word[HALF_W-1:0];
  wire [HALF_W-1:0] cmp_half = hi_seg ? cmp_q[WORD_W-1:HALF_W] : cmp_q[HALF_W-1:0];

  logic [HALF_W-1:0] rd_nxt;
  always_comb begin
    rd_nxt = '0;
    if (is_mem)       rd_nxt = old_half;
    else if (is_mreg) rd_nxt = mr_half;
    else if (is_cmp)  rd_nxt = cmp_half;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
      for (int i = 0; i < NMASK; i++) mreg[i] <= '0;
      valid <= '0;
      cmp_q <= '0;
    end else if (do_wr) begin
      if (is_mem) begin
        if (hi_seg) mem[mem_addr][WORD_W-1:HALF_W] <= new_half;
        else        mem[mem_addr][HALF_W-1:0]      <= new_half;
        valid[mem_addr] <= !vld_in_n;
      end else if (is_mreg && msel != '0) begin
        if (hi_seg) mreg[msel][WORD_W-1:HALF_W] <= wdata;
        else        mreg[msel][HALF_W-1:0]      <= wdata;
      end else if (is_cmp) begin
        if (hi_seg) cmp_q[WORD_W-1:HALF_W] <= wdata;
        else        cmp_q[HALF_W-1:0]      <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ar_q  <= '0;
      cfg_q <= '0;
    end else begin
      if (ar_ld)  ar_q  <= ar_val;
      if (cfg_ld) cfg_q <= cfg_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata     <= '0;
      vld_out_n <= 1'b1;
    end else if (cyc) begin
      rdata     <= do_rd ? rd_nxt : '0;
      vld_out_n <= !(do_rd && is_mem && valid[mem_addr]);
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc |=> ($stable(rdata) && $stable(vld_out_n))); // R11
  AST_WRITE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc && !wr_n) |=> (rdata == '0)); // R12
  AST_UNKNOWN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc && !addr_strobe_n == 1'b0 && ctl[5:0] != OP_IND && ctl[5:0] != OP_MASK
     && ctl[5:0] != OP_CMP) |=> (rdata == '0 && vld_out_n)); // R10
  AST_MR0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc && wr_n && addr_strobe_n && ctl[5:0] == OP_MASK && ctl[6 +: MSEL_W] == '0)
    |=> (rdata == '0)); // R7
  AST_VLD_NONMEM: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc && addr_strobe_n && ctl[5:0] != OP_IND) |=> vld_out_n); // R3
endmodule

// File: tb/seg_mem_access_bench.sv
module seg_mem_access_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cyc, av_n, wr_n, hi, vin_n, ar_ld, cfg_ld, vout_n;
  logic [11:0] ctl;
  logic [31:0] wd, rd;
  logic [5:0]  ar_val;
  logic [3:0]  cfg_val;
  int checks = 0, errors = 0;

  seg_mem_access u_seg_mem_access (
    .clk(clk), .rst_n(rst_n), .cyc(cyc), .addr_strobe_n(av_n), .wr_n(wr_n),
    .hi_seg(hi), .ctl(ctl), .wdata(wd), .vld_in_n(vin_n), .ar_ld(ar_ld),
    .ar_val(ar_val), .cfg_ld(cfg_ld), .cfg_val(cfg_val), .rdata(rd), .vld_out_n(vout_n));

  typedef struct packed {
    logic av_n; logic wr_n; logic hi; logic [11:0] ctl; logic [31:0] wd;
    logic vin_n; logic [31:0] erd; logic evn; logic [3:0] req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,12'h003,32'hAAAA5555,1'b0,32'h0,1'b1,4'd2},       // R2 direct write lo
    '{1'b0,1'b0,1'b1,12'h003,32'h12345678,1'b0,32'h0,1'b1,4'd12},      // R12 direct write hi
    '{1'b0,1'b1,1'b0,12'h003,32'h0,1'b1,32'hAAAA5555,1'b0,4'd2},       // R2 read lo
    '{1'b0,1'b1,1'b1,12'h003,32'h0,1'b1,32'h12345678,1'b0,4'd4},       // R4 read hi
    '{1'b1,1'b0,1'b0,12'h049,32'hFFFF0000,1'b0,32'h0,1'b1,4'd7},       // R7 write MR1 lo
    '{1'b1,1'b1,1'b0,12'h049,32'h0,1'b0,32'hFFFF0000,1'b1,4'd7},       // R7 read MR1 lo
    '{1'b1,1'b1,1'b1,12'h049,32'h0,1'b0,32'h0,1'b1,4'd7},              // R7 MR1 hi untouched
    '{1'b1,1'b0,1'b0,12'h000,32'h11111111,1'b0,32'h0,1'b1,4'd5},       // R5 indirect write
    '{1'b1,1'b1,1'b0,12'h000,32'h0,1'b1,32'h11111111,1'b0,4'd5},       // R5 indirect read
    '{1'b1,1'b0,1'b0,12'h040,32'h22222222,1'b0,32'h0,1'b1,4'd6},       // R6 masked by MR1
    '{1'b1,1'b1,1'b0,12'h000,32'h0,1'b1,32'h11112222,1'b0,4'd6},       // R6 result
    '{1'b1,1'b0,1'b0,12'h009,32'hFFFFFFFF,1'b0,32'h0,1'b1,4'd7},       // R7 write MR0
    '{1'b1,1'b1,1'b0,12'h009,32'h0,1'b0,32'h0,1'b1,4'd7},              // R7 read MR0
    '{1'b1,1'b0,1'b0,12'h000,32'h33333333,1'b0,32'h0,1'b1,4'd6},       // R6 msel 0 unmasked
    '{1'b1,1'b1,1'b0,12'h000,32'h0,1'b1,32'h33333333,1'b0,4'd6},       // R6 result
    '{1'b1,1'b0,1'b0,12'h005,32'hDEADBEEF,1'b0,32'h0,1'b1,4'd9},       // R9 comparand write
    '{1'b1,1'b1,1'b0,12'h005,32'h0,1'b0,32'hDEADBEEF,1'b1,4'd9},       // R9 read lo
    '{1'b1,1'b1,1'b1,12'h005,32'h0,1'b0,32'h0,1'b1,4'd9},              // R9 read hi
    '{1'b1,1'b0,1'b0,12'h03F,32'hFFFFFFFF,1'b0,32'h0,1'b1,4'd10},      // R10 unknown write
    '{1'b1,1'b1,1'b0,12'h03F,32'h0,1'b0,32'h0,1'b1,4'd10},             // R10 unknown read
    '{1'b1,1'b1,1'b0,12'h000,32'h0,1'b0,32'h33333333,1'b0,4'd10},      // R10 array unchanged
    '{1'b0,1'b1,1'b0,12'h007,32'h0,1'b0,32'h0,1'b1,4'd1},              // R1 never written entry
    '{1'b0,1'b0,1'b0,12'h007,32'h00000005,1'b1,32'h0,1'b1,4'd3},       // R3 write as empty
    '{1'b0,1'b1,1'b0,12'h007,32'h0,1'b0,32'h00000005,1'b1,4'd3}        // R3 read empty
  };

  task automatic check(input int req, input logic [31:0] erd, input logic evn);
    checks++;
    if (rd !== erd || vout_n !== evn) begin
      errors++;
      $display("FAIL R%0d: rdata=%h vld_out_n=%b expected %h %b", req, rd, vout_n, erd, evn);
    end
  endtask

  task automatic op(input logic a, input logic w, input logic h, input logic [11:0] c,
                    input logic [31:0] d, input logic v);
    av_n = a; wr_n = w; hi = h; ctl = c; wd = d; vin_n = v; cyc = 1'b1;
    @(posedge clk); @(negedge clk);
    cyc = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cyc = 1'b0; av_n = 1'b1; wr_n = 1'b1; hi = 1'b0; ctl = '0; wd = '0;
    vin_n = 1'b1; ar_ld = 1'b0; ar_val = '0; cfg_ld = 1'b0; cfg_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(1, 32'h0, 1'b1); // R1 reset outputs
    ar_val = 6'd5; ar_ld = 1'b1;
    @(negedge clk);
    ar_ld = 1'b0;
    for (int i = 0; i < NV; i++) begin
      op(VEC[i].av_n, VEC[i].wr_n, VEC[i].hi, VEC[i].ctl, VEC[i].wd, VEC[i].vin_n);
      check(int'(VEC[i].req), VEC[i].erd, VEC[i].evn);
    end
    // R8 direct write masked through configuration (enable, MR1)
    cfg_val = 4'b1001; cfg_ld = 1'b1;
    @(negedge clk);
    cfg_ld = 1'b0;
    op(1'b0, 1'b0, 1'b0, 12'h003, 32'h00000000, 1'b0);
    op(1'b0, 1'b1, 1'b0, 12'h003, 32'h0, 1'b1);
    check(8, 32'hAAAA0000, 1'b0);
    // R8 masking disabled again
    cfg_val = 4'b0001; cfg_ld = 1'b1;
    @(negedge clk);
    cfg_ld = 1'b0;
    op(1'b0, 1'b0, 1'b0, 12'h003, 32'h0000BEEF, 1'b0);
    op(1'b0, 1'b1, 1'b0, 12'h003, 32'h0, 1'b1);
    check(8, 32'h0000BEEF, 1'b0);
    // R4 other half intact
    op(1'b0, 1'b1, 1'b1, 12'h003, 32'h0, 1'b1);
    check(4, 32'h12345678, 1'b0);
    // R11 idle cycles with write-looking inputs change nothing
    av_n = 1'b0; wr_n = 1'b0; hi = 1'b1; ctl = 12'h003; wd = 32'hFFFFFFFF; cyc = 1'b0;
    repeat (3) @(negedge clk);
    check(11, 32'h12345678, 1'b0);
    op(1'b0, 1'b1, 1'b1, 12'h003, 32'h0, 1'b1);
    check(11, 32'h12345678, 1'b0);
    // R5 address register reload
    ar_val = 6'd3; ar_ld = 1'b1;
    @(negedge clk);
    ar_ld = 1'b0;
    op(1'b1, 1'b1, 1'b1, 12'h000, 32'h0, 1'b1);
    check(5, 32'h12345678, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule